// File: doc/BRIEF.md
# Interrupt Pin Redirection Entry

This block is a single routing slot of an I/O interrupt router. It watches one external interrupt line, conditions it through a synchronizer, applies a programmable polarity, and turns either a fresh activation (edge trigger) or a sustained activation (level trigger) into a delivery request. Each request carries an 8-bit vector and a destination. The request goes to a message sender over a valid/accept handshake.

Software sees the slot as one 64-bit configuration word, accessed as a lower and an upper 32-bit half, each with its own write strobe. Two bits of the lower half are status flags that writes cannot alter:

- **Send-pending:** a request has been raised but not yet taken.
- **Level-in-service:** a level request was taken and its end-of-interrupt has not arrived.

For level triggering, the in-service flag keeps the line from firing again until an end-of-interrupt notice carrying the slot's vector is seen. After that notice the line is evaluated afresh.

Top module: `irq_route_entry`

## Requirements
- R1: After reset, `rd_lo` reads 0x00010000 (mask set, every other field 0), `rd_hi` reads 0 and `req_valid` is 0.
- R2: A write to the lower half updates these fields:
  - vector from bits 7:0;
  - destination mode from bit 11;
  - polarity from bit 13;
  - trigger mode from bit 15;
  - mask from bit 16.

  Bit 12 (send-pending) and bit 14 (level-in-service) are read-only, and writes to them are ignored. A write to the upper half updates the destination byte in bits 31:24 (bits 63:56 of the full word). All other bits read 0.
- R3: The pin passes through a two-flop synchronizer. Polarity bit 0 means active-high and 1 means active-low. An edge is an inactive-to-active change after polarity is applied. `req_valid` rises at the third rising clock edge after the pin changes.
- R4: In edge mode (bit 15 = 0), an unmasked edge sets send-pending (bit 12) and `req_valid`. Both clear one clock after a cycle with `req_valid` and `req_accept` both high.
- R5: An edge that arrives while the mask is 1 is discarded. Clearing the mask afterwards while the pin stays active raises no request.
- R6: In level mode (bit 15 = 1), a request is raised while the pin is active, the slot is unmasked, and level-in-service (bit 14) is 0. Acceptance of a level request sets bit 14, and no further request is raised while bit 14 is 1.
- R7: An end-of-interrupt (`eoi_valid`) whose `eoi_vector` equals the slot's vector clears bit 14. A non-matching one has no effect. If the pin is still active and the slot is unmasked, a new request follows one clock after the clear.
- R8: A masked level pin raises no request and leaves bit 14 unchanged.
- R9: Once raised, a request holds `req_valid`, `req_vector`, `req_dest` and `req_level` steady until accepted. Later register writes, including setting the mask, do not withdraw it. Setting the mask after acceptance leaves bit 14 at 1 until a matching end-of-interrupt.
- R10: `req_vector` is the vector field.
  - In physical mode (bit 11 = 0), `req_dest` is {4'b0, bits 59:56}.
  - In logical mode (bit 11 = 1), `req_dest` is the full byte of bits 63:56.
- R11: Same-cycle cases:
  - An edge that coincides with acceptance leaves a new request pending.
  - A matching end-of-interrupt in the cycle that a level request is accepted leaves bit 14 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous interrupt line |
| wr_lo_en | input | 1 | Write strobe for the lower configuration half |
| wr_hi_en | input | 1 | Write strobe for the upper configuration half |
| wr_data | input | 32 | Write data for either half |
| rd_lo | output | 32 | Lower configuration half, including status bits |
| rd_hi | output | 32 | Upper configuration half |
| req_valid | output | 1 | Delivery request outstanding |
| req_accept | input | 1 | Sender takes the request |
| req_vector | output | 8 | Vector of the outstanding request |
| req_dest | output | 8 | Resolved destination of the outstanding request |
| req_logical | output | 1 | Destination mode of the outstanding request |
| req_level | output | 1 | Outstanding request is level-triggered |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt notice |

## Verification
Two pairs of functions can land in the same clock.

- **Acceptance and a new edge.** An edge can arrive in the very cycle a pending request is accepted. The bench times a second pin rise so that its detected edge lines up with the accept strobe. It then expects `req_valid` still high on the next cycle, with a second accept needed to drain it.
- **Acceptance and end-of-interrupt.** Acceptance of a level request can coincide with a matching end-of-interrupt. The bench drives both strobes together and expects bit 14 to read 1 afterwards, since the notice belongs to an earlier interrupt.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  parameter int VEC_W   = 8;
  parameter int DEST_W  = 8;
  parameter int PHYS_W  = 4;
  parameter int HALF_W  = 32;

  // lower-half field positions (decoded by software, so fixed)
  localparam int POS_MASK  = 16;
  localparam int POS_TRIG  = 15;
  localparam int POS_RIRR  = 14;
  localparam int POS_POL   = 13;
  localparam int POS_DSTAT = 12;
  localparam int POS_DMODE = 11;
  // upper-half destination offset (bits 63:56 of the word)
  localparam int POS_DEST  = HALF_W - DEST_W;

  typedef struct packed {
    logic              mask;
    logic              trig;   // 1 level, 0 edge
    logic              pol;    // 1 active-low
    logic              dmode;  // 1 logical
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
  } cfg_t;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    logic [DEST_W-1:0] dest;
    logic              logical;
    logic              level;
  } payload_t;

  function automatic logic [DEST_W-1:0] route_dest(input logic dmode,
                                                   input logic [DEST_W-1:0] field);
    logic [DEST_W-1:0] r;
    r = field;
    if (!dmode) r = {{(DEST_W-PHYS_W){1'b0}}, field[PHYS_W-1:0]};
    return r;
  endfunction

  function automatic logic [HALF_W-1:0] pack_lo(input cfg_t c, input logic dstat,
                                               input logic rirr);
    logic [HALF_W-1:0] w;
    w = '0;
    w[VEC_W-1:0] = c.vec;
    w[POS_DMODE] = c.dmode;
    w[POS_DSTAT] = dstat;
    w[POS_POL]   = c.pol;
    w[POS_RIRR]  = rirr;
    w[POS_TRIG]  = c.trig;
    w[POS_MASK]  = c.mask;
    return w;
  endfunction

  function automatic logic [HALF_W-1:0] pack_hi(input cfg_t c);
    logic [HALF_W-1:0] w;
    w = '0;
    w[HALF_W-1:POS_DEST] = c.dest;
    return w;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic pol,
  output logic active,
  output logic edge_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin_raw};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= pin_raw;
    end
  endgenerate

  assign active = chain[STAGES-1] ^ pol;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= active;

  assign edge_evt = active & ~prev_q;
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              dstat,
  input  logic              rirr,
  output cfg_t              cfg,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi
);
  cfg_t cfg_q;
  logic unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cfg_q.mask <= 1'b1;
    end else begin
      if (wr_lo_en) begin
        cfg_q.vec   <= wr_data[VEC_W-1:0];
        cfg_q.dmode <= wr_data[POS_DMODE];
        cfg_q.pol   <= wr_data[POS_POL];
        cfg_q.trig  <= wr_data[POS_TRIG];
        cfg_q.mask  <= wr_data[POS_MASK];
      end
      if (wr_hi_en)
        cfg_q.dest <= wr_data[HALF_W-1:POS_DEST];
    end
  end

  assign unused_wr_bits = ^wr_data;
  assign cfg   = cfg_q;
  assign rd_lo = pack_lo(cfg_q, dstat, rirr);
  assign rd_hi = pack_hi(cfg_q);
endmodule

// File: rtl/irq_deliver_ctl.sv
module irq_deliver_ctl
  import irq_route_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             active,
  input  logic             edge_evt,
  input  logic             req_accept,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             pend_q,
  output logic             rirr_q,
  output payload_t         pay_q,
  output logic             accept_fire,
  output logic             eoi_hit
);
  logic issue_edge, issue_level, issue, load;

  assign accept_fire = pend_q & req_accept;
  assign eoi_hit     = eoi_valid & (eoi_vector == cfg.vec);

  assign issue_edge  = ~cfg.trig & edge_evt & ~cfg.mask;
  assign issue_level = cfg.trig & active & ~cfg.mask & ~rirr_q & ~pend_q;
  assign issue       = issue_edge | issue_level;
  // a new request is captured only into an empty or draining slot
  assign load        = issue & (~pend_q | accept_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pay_q  <= '0;
    end else begin
      if (load) begin
        pend_q        <= 1'b1;
        pay_q.vec     <= cfg.vec;
        pay_q.dest    <= route_dest(cfg.dmode, cfg.dest);
        pay_q.logical <= cfg.dmode;
        pay_q.level   <= cfg.trig;
      end else if (accept_fire) begin
        pend_q <= 1'b0;
      end
    end
  end

  // acceptance of a level request outranks a coincident EOI
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rirr_q <= 1'b0;
    else if (accept_fire && pay_q.level) rirr_q <= 1'b1;
    else if (eoi_hit)                    rirr_q <= 1'b0;
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              wr_lo_en,
  input  logic              wr_hi_en,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] rd_lo,
  output logic [HALF_W-1:0] rd_hi,
  output logic              req_valid,
  input  logic              req_accept,
  output logic [VEC_W-1:0]  req_vector,
  output logic [DEST_W-1:0] req_dest,
  output logic              req_logical,
  output logic              req_level,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector
);
  cfg_t     cfg;
  payload_t pay_q;
  logic     active, edge_evt;
  logic     pend_q, rirr_q, accept_fire, eoi_hit, mask_q;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pol(cfg.pol),
    .active(active), .edge_evt(edge_evt)
  );

  irq_entry_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
    .wr_data(wr_data), .dstat(pend_q), .rirr(rirr_q), .cfg(cfg),
    .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  irq_deliver_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .active(active), .edge_evt(edge_evt),
    .req_accept(req_accept), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .pend_q(pend_q), .rirr_q(rirr_q), .pay_q(pay_q),
    .accept_fire(accept_fire), .eoi_hit(eoi_hit)
  );

  assign mask_q      = cfg.mask;
  assign req_valid   = pend_q;
  assign req_vector  = pay_q.vec;
  assign req_dest    = pay_q.dest;
  assign req_logical = pay_q.logical;
  assign req_level   = pay_q.level;
endmodule

// File: rtl/irq_route_entry_chk.sv
module irq_route_entry_chk
  import irq_route_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_accept,
  input logic [VEC_W-1:0]  req_vector,
  input logic [DEST_W-1:0] req_dest,
  input logic              req_level,
  input logic              mask_q,
  input logic              rirr_q,
  input logic              accept_fire,
  input logic              eoi_hit
);
  assert_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |=> req_valid);

  assert_payload_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_accept) |=> ($stable(req_vector) && $stable(req_dest)));

  assert_masked_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !req_valid) |=> !req_valid);

  assert_rirr_from_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rirr_q) |-> $past(accept_fire));

  assert_level_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_level) |-> !$past(rirr_q));

  assert_eoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !(accept_fire && req_level)) |=> !rirr_q);
endmodule

bind irq_route_entry irq_route_entry_chk u_chk (.*);

// File: tb/sim_irq_route_entry.sv
`timescale 1ns/1ps
module sim_irq_route_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_raw = 1'b0;
  logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_lo, rd_hi;
  logic        req_valid, req_accept = 1'b0;
  logic [7:0]  req_vector, req_dest;
  logic        req_logical, req_level;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_route_entry u0 (.*);

  // rows: lower word, upper word, active raw pin level, request expected
  localparam int NROW = 7;
  localparam logic [31:0] T_LO [NROW] = '{32'h00000031, 32'h00002042, 32'h00000853,
    32'h00010060, 32'h00008070, 32'h00018071, 32'h0000A880};
  localparam logic [31:0] T_HI [NROW] = '{32'hA5000000, 32'h3C000000, 32'hC3000000,
    32'h11000000, 32'h12000000, 32'h22000000, 32'h7E000000};
  localparam logic T_ACT [NROW] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic T_EXP [NROW] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  function automatic logic [7:0] want_dest(input logic [31:0] lo, input logic [31:0] hi);
    if (lo[11]) return hi[31:24];
    return {4'h0, hi[27:24]};
  endfunction

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic idle);
    rst_n = 1'b0; pin_raw = idle; req_accept = 1'b0; eoi_valid = 1'b0;
    tick(2); rst_n = 1'b1; tick(3);
  endtask

  task automatic wr_lo(input logic [31:0] d);
    wr_data = d; wr_lo_en = 1'b1; tick(); wr_lo_en = 1'b0;
  endtask

  task automatic wr_hi(input logic [31:0] d);
    wr_data = d; wr_hi_en = 1'b1; tick(); wr_hi_en = 1'b0;
  endtask

  task automatic accept();
    req_accept = 1'b1; tick(); req_accept = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v; tick(); eoi_valid = 1'b0;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(1'b0);
    chk("R1 rd_lo", rd_lo, 32'h00010000);
    chk("R1 rd_hi", rd_hi, 32'h0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'h0);

    // R2 field write, read-only bits 12 and 14 untouched
    wr_lo(32'hFFFFFFFF);
    chk("R2 rd_lo", rd_lo, 32'h0001A8FF);
    wr_hi(32'hFFFFFFFF);
    chk("R2 rd_hi", rd_hi, 32'hFF000000);

    // table walk: R3 R4 R5 R6 R8 R10
    for (int r = 0; r < NROW; r++) begin
      do_reset(~T_ACT[r]);
      wr_hi(T_HI[r]);
      wr_lo(T_LO[r]);
      tick(3);
      pin_raw = T_ACT[r];
      tick(3);
      chk($sformatf("R3/R4/R6 row%0d req_valid", r), {31'b0, req_valid}, {31'b0, T_EXP[r]});
      if (T_EXP[r]) begin
        chk($sformatf("R10 row%0d vector", r), {24'b0, req_vector}, {24'b0, T_LO[r][7:0]});
        chk($sformatf("R10 row%0d dest", r), {24'b0, req_dest}, {24'b0, want_dest(T_LO[r], T_HI[r])});
        chk($sformatf("R10 row%0d level", r), {31'b0, req_level}, {31'b0, T_LO[r][15]});
      end
    end

    // R3 latency, R4 status and clear, R9 hold through writes
    do_reset(1'b0);
    wr_hi(32'h05000000);
    wr_lo(32'h00000031);
    pin_raw = 1'b1;
    tick(2);
    chk("R3 not yet", {31'b0, req_valid}, 32'h0);
    tick();
    chk("R3 third edge", {31'b0, req_valid}, 32'h1);
    chk("R4 status bit12", rd_lo, 32'h00001031);
    wr_lo(32'h00010099);
    chk("R9 valid after mask", {31'b0, req_valid}, 32'h1);
    chk("R9 vector held", {24'b0, req_vector}, 32'h31);
    wr_lo(32'h00000031);
    accept();
    chk("R4 cleared", {31'b0, req_valid}, 32'h0);
    chk("R4 bit12 cleared", rd_lo & 32'h1000, 32'h0);

    // R11 edge coincident with acceptance
    pin_raw = 1'b0; tick(3);
    pin_raw = 1'b1; tick(3);
    chk("R11 first pending", {31'b0, req_valid}, 32'h1);
    pin_raw = 1'b0; tick(3);
    pin_raw = 1'b1; tick(2);
    accept();
    chk("R11 re-pended", {31'b0, req_valid}, 32'h1);
    accept();
    chk("R11 drained", {31'b0, req_valid}, 32'h0);

    // R5 masked edge dropped, then unmask while active
    do_reset(1'b0);
    wr_lo(32'h00010020);
    pin_raw = 1'b1; tick(4);
    wr_lo(32'h00000020);
    tick(4);
    chk("R5 no request", {31'b0, req_valid}, 32'h0);

    // R6 R7 level handshake
    do_reset(1'b0);
    wr_lo(32'h00008044);
    pin_raw = 1'b1; tick(3);
    chk("R6 level request", {31'b0, req_valid}, 32'h1);
    chk("R6 bit12 set", rd_lo, 32'h00009044);
    accept();
    chk("R6 bit14 set", rd_lo, 32'h0000C044);
    tick(3);
    chk("R6 held off", {31'b0, req_valid}, 32'h0);
    eoi(8'h45);
    chk("R7 mismatch keeps bit14", rd_lo & 32'h4000, 32'h4000);
    eoi(8'h44);
    chk("R7 match clears bit14", rd_lo & 32'h4000, 32'h0);
    chk("R7 not yet reissued", {31'b0, req_valid}, 32'h0);
    tick();
    chk("R7 reissued", {31'b0, req_valid}, 32'h1);

    // R11 acceptance with matching EOI in the same cycle
    req_accept = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h44;
    tick();
    req_accept = 1'b0; eoi_valid = 1'b0;
    chk("R11 bit14 survives", rd_lo & 32'h4000, 32'h4000);
    chk("R11 valid dropped", {31'b0, req_valid}, 32'h0);

    // R9 mask after acceptance, R8 masked level
    wr_lo(32'h00018044);
    chk("R9 bit14 kept after mask", rd_lo, 32'h0001C044);
    eoi(8'h44);
    chk("R8 bit14 cleared", rd_lo, 32'h00018044);
    tick(3);
    chk("R8 masked no request", {31'b0, req_valid}, 32'h0);
    chk("R8 bit14 unchanged", rd_lo & 32'h4000, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule